// File: doc/BRIEF.md
# Continuous-Read Converter Host

This block is the host end of a serial link to a sigma-delta converter whose data output also serves as its "conversion ready" flag. A start request makes the host lower chip select and shift the enter-streaming command to the converter. The host never issues a read command for each word. It watches the shared data/ready line and, each time that line falls, applies exactly one word's worth of serial clocks. It then delivers the assembled word with a one-cycle strobe.

The serial clock comes from a divider of the system clock. It idles high, and both ends sample on its rising edge. The command line stays low whenever no command byte is being shifted, so the converter never sees a long run of ones and never resets itself. A stop request is held pending. The exit command is shifted only while the ready line is low, and only after any word already in flight has been completely read. A sticky overrun flag reports that a new conversion began before the consumer acknowledged the previous word.

Top module: `cread_host`

## Requirements
- R1: After reset, chip select is high, the serial clock is high, the command line is low, and the word strobe and the overrun flag are low.
- R2: A start request in the idle state lowers chip select and shifts 0x5C most significant bit first. The command line changes only while the serial clock is low. Each serial clock half period lasts DIV system clocks, and chip select stays low for the whole session.
- R3: After the enter command, no serial clock edge occurs until the data/ready line is seen low.
- R4: Each low on the data/ready line produces exactly WORD_W serial clock pulses. Data is captured on their rising edges, most significant bit first, and the word appears on word_o together with a strobe one system clock long.
- R5: After a word is read, the host waits for the data/ready line to return high before it accepts a new low, so that no conversion is read twice.
- R6: Outside command bytes, the command line is held low during streaming, and the converter never sees 40 consecutive ones.
- R7: After a stop request, 0x58 is shifted only once the data/ready line is seen low, and chip select then returns high. That exit delivers no word.
- R8: A stop request that arrives while a word is being read takes effect only after that word has been read and delivered.
- R9: The overrun flag sets when a new read begins while the previous word is still unacknowledged. It stays set until the next accepted start.
- R10: A start request during a session and a stop request while idle have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to begin streaming |
| stop_i | input | 1 | Request to end streaming |
| ack_i | input | 1 | Consumer acknowledges the last delivered word |
| rdy_dout_i | input | 1 | Shared converter data output and ready flag |
| sclk_o | output | 1 | Serial clock, idle high |
| din_o | output | 1 | Command line to the converter |
| cs_n_o | output | 1 | Active-low chip select |
| word_o | output | WORD_W | Last received conversion word |
| word_vld_o | output | 1 | One-cycle strobe for word_o |
| overrun_o | output | 1 | Sticky unacknowledged-word flag |

## Verification
The hardest situation to reach is a stop request that lands inside a word being clocked. The request must wait for the end of that word and then for a fresh ready before the exit byte appears. The bench gets there with a behavioural converter model that keeps its own bit count: it raises the stop only once the model reports several bits of the current word shifted. It then checks that the word was delivered and that the exit was seen by the model. The overrun case is reached by withholding the acknowledge across two conversions whose spacing is drawn at random.

// File: rtl/cread_pkg.sv
package cread_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_WLOW,
        ST_WHIGH,
        ST_READ,
        ST_END
    } cread_st_e;

    localparam logic [7:0] CR_ENTER = 8'h5C;
    localparam logic [7:0] CR_EXIT  = 8'h58;

endpackage

// File: rtl/cread_tick.sv
module cread_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!en_i || cnt_q == LAST) cnt_d = '0;
        else                        cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/cread_ovr.sv
module cread_ovr (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic vld_i,
    input  logic ack_i,
    input  logic begin_i,
    output logic overrun_o
);
    logic pend_d, pend_q, ovr_d, ovr_q;

    always_comb begin
        pend_d = (pend_q | vld_i) & ~ack_i;
        ovr_d  = ovr_q | (begin_i & pend_q);
        if (clr_i) begin
            pend_d = 1'b0;
            ovr_d  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            pend_q <= pend_d;
            ovr_q  <= ovr_d;
        end
    end

    assign overrun_o = ovr_q;
endmodule

// File: rtl/cread_host.sv
module cread_host
    import cread_pkg::*;
#(
    parameter int DIV    = 4,
    parameter int WORD_W = 24,
    parameter int CMD_W  = 8,
    parameter logic [CMD_W-1:0] ENTER_CODE = CMD_W'(CR_ENTER),
    parameter logic [CMD_W-1:0] EXIT_CODE  = CMD_W'(CR_EXIT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              ack_i,
    input  logic              rdy_dout_i,
    output logic              sclk_o,
    output logic              din_o,
    output logic              cs_n_o,
    output logic [WORD_W-1:0] word_o,
    output logic              word_vld_o,
    output logic              overrun_o
);
    localparam int MAXB  = (WORD_W > CMD_W) ? WORD_W : CMD_W;
    localparam int CNT_W = $clog2(MAXB);
    localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0] WORD_LAST = CNT_W'(WORD_W - 1);

    typedef struct packed {
        cread_st_e         st;
        logic              csn;
        logic              sclk;
        logic              din;
        logic              stop_pend;
        logic              exit;
        logic              vld;
        logic [CMD_W-1:0]  cmd;
        logic [WORD_W-1:0] sh;
        logic [WORD_W-1:0] word;
        logic [CNT_W-1:0]  cnt;
    } regs_t;

    localparam regs_t RST = '{st: ST_IDLE, csn: 1'b1, sclk: 1'b1, din: 1'b0,
                              stop_pend: 1'b0, exit: 1'b0, vld: 1'b0,
                              cmd: '0, sh: '0, word: '0, cnt: '0};

    regs_t r_d, r_q;
    logic  tick, tick_en, rd_begin, start_ok;

    assign tick_en  = (r_q.st == ST_CMD) || (r_q.st == ST_READ);
    assign start_ok = (r_q.st == ST_IDLE) && start_i;
    assign rd_begin = (r_q.st == ST_WLOW) && !rdy_dout_i && !(r_q.stop_pend || stop_i);

    cread_tick #(.DIV(DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (tick_en),
        .tick_o (tick)
    );

    cread_ovr u_ovr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (start_ok),
        .vld_i     (r_q.vld),
        .ack_i     (ack_i),
        .begin_i   (rd_begin),
        .overrun_o (overrun_o)
    );

    always_comb begin
        r_d     = r_q;
        r_d.vld = 1'b0;
        if (r_q.st != ST_IDLE && stop_i) r_d.stop_pend = 1'b1;
        unique case (r_q.st)
            ST_IDLE: begin
                r_d.csn       = 1'b1;
                r_d.sclk      = 1'b1;
                r_d.din       = 1'b0;
                r_d.stop_pend = 1'b0;
                if (start_i) begin
                    r_d.st   = ST_CMD;
                    r_d.csn  = 1'b0;
                    r_d.cmd  = ENTER_CODE;
                    r_d.exit = 1'b0;
                    r_d.cnt  = '0;
                end
            end
            ST_CMD: begin
                if (tick) begin
                    if (r_q.sclk) begin
                        r_d.sclk = 1'b0;
                        r_d.din  = r_q.cmd[CMD_W-1];
                        r_d.cmd  = {r_q.cmd[CMD_W-2:0], 1'b0};
                    end else begin
                        r_d.sclk = 1'b1;
                        r_d.cnt  = r_q.cnt + 1'b1;
                        if (r_q.cnt == CMD_LAST) begin
                            r_d.cnt = '0;
                            r_d.st  = r_q.exit ? ST_END : ST_WLOW;
                        end
                    end
                end
            end
            ST_WLOW: begin
                r_d.din = 1'b0;
                if (!rdy_dout_i) begin
                    r_d.cnt = '0;
                    if (r_d.stop_pend) begin
                        r_d.st   = ST_CMD;
                        r_d.cmd  = EXIT_CODE;
                        r_d.exit = 1'b1;
                    end else begin
                        r_d.st = ST_READ;
                    end
                end
            end
            ST_READ: begin
                r_d.din = 1'b0;
                if (tick) begin
                    if (r_q.sclk) begin
                        r_d.sclk = 1'b0;
                    end else begin
                        r_d.sclk = 1'b1;
                        r_d.sh   = {r_q.sh[WORD_W-2:0], rdy_dout_i};
                        r_d.cnt  = r_q.cnt + 1'b1;
                        if (r_q.cnt == WORD_LAST) begin
                            r_d.cnt  = '0;
                            r_d.word = {r_q.sh[WORD_W-2:0], rdy_dout_i};
                            r_d.vld  = 1'b1;
                            r_d.st   = ST_WHIGH;
                        end
                    end
                end
            end
            ST_WHIGH: begin
                r_d.din = 1'b0;
                if (rdy_dout_i) r_d.st = ST_WLOW;
            end
            ST_END: begin
                r_d.csn  = 1'b1;
                r_d.din  = 1'b0;
                r_d.exit = 1'b0;
                r_d.st   = ST_IDLE;
            end
            default: r_d = RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RST;
        else        r_q <= r_d;
    end

    assign sclk_o     = r_q.sclk;
    assign din_o      = r_q.din;
    assign cs_n_o     = r_q.csn;
    assign word_o     = r_q.word;
    assign word_vld_o = r_q.vld;
endmodule

// File: rtl/cread_host_chk.sv
module cread_host_chk
    import cread_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input cread_st_e st,
    input logic      exit_q,
    input logic      start_i,
    input logic      rdy_dout_i,
    input logic      sclk_o,
    input logic      din_o,
    input logic      cs_n_o,
    input logic      word_vld_o,
    input logic      overrun_o
);
    // R1
    idle_clock_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> sclk_o);

    // R2
    session_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) |-> !cs_n_o);

    // R3
    wait_no_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WLOW || st == ST_WHIGH) |-> sclk_o);

    // R4
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld_o |=> !word_vld_o);

    // R6
    din_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_READ || st == ST_WHIGH) |-> !din_o);

    // R7
    exit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CMD && exit_q && $past(st) == ST_WLOW) |-> $past(!rdy_dout_i));

    // R9
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun_o && !(st == ST_IDLE && start_i)) |=> overrun_o);
endmodule

bind cread_host cread_host_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .st         (r_q.st),
    .exit_q     (r_q.exit),
    .start_i    (start_i),
    .rdy_dout_i (rdy_dout_i),
    .sclk_o     (sclk_o),
    .din_o      (din_o),
    .cs_n_o     (cs_n_o),
    .word_vld_o (word_vld_o),
    .overrun_o  (overrun_o)
);

// File: tb/cread_host_test.sv
module cread_host_test;
    localparam int DIV = 2;
    localparam int WW  = 24;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 1'b0, stop = 1'b0, ack = 1'b1, dr = 1'b1;
    logic sclk, din, csn, vld, ovr;
    logic [WW-1:0] word;

    int nchk = 0, nfail = 0;

    always #4 clk = ~clk;

    cread_host #(.DIV(DIV), .WORD_W(WW)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .stop_i(stop), .ack_i(ack),
        .rdy_dout_i(dr), .sclk_o(sclk), .din_o(din), .cs_n_o(csn),
        .word_o(word), .word_vld_o(vld), .overrun_o(ovr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [WW-1:0] exp_word(input logic [31:0] raw);
        return raw[WW-1:0];
    endfunction

    // behavioural converter model, evaluated between clock edges
    bit mc = 0, pres = 0;
    logic sprev = 1'b1;
    logic [7:0] csh = '0, dsh = '0, last_cmd = '0;
    logic [31:0] cur = '0;
    int cmd_cnt = 0, rbits = 0, bidx = 0, ones = 0, run = 0;
    int since = 0, hp_min = 1000, hp_max = 0;
    int bad_edges = 0, reads = 0, dirty = 0, floods = 0, exits = 0, enters = 0;
    int lost = 0, vcount = 0, timer = 60;

    always @(negedge clk) begin
        bit rise, fall;
        rise = sclk && !sprev;
        fall = !sclk && sprev;
        sprev = sclk;
        if (rst_n) begin
            if (vld) begin
                vcount++;
                chk(word == exp_word(cur), "R4 word", int'(word), int'(exp_word(cur)));
            end
            if (rise || fall) begin
                if (!mc && !csn && (rise || cmd_cnt > 0)) begin
                    if (since < hp_min) hp_min = since;
                    if (since > hp_max) hp_max = since;
                end
                since = 1;
            end else since++;
            if (rise && !csn) begin
                run = din ? run + 1 : 0;
                if (run >= 40) floods++;
            end
            if (csn) begin
                cmd_cnt = 0;
                dr = 1'b1;
            end else if (!mc) begin
                if (rise) begin
                    csh = {csh[6:0], din};
                    cmd_cnt++;
                    if (cmd_cnt == 8) begin
                        last_cmd = csh;
                        cmd_cnt = 0;
                        if (csh == 8'h5C) begin mc = 1; enters++; end
                    end
                end
            end else if (pres) begin
                if (fall) begin
                    dr = cur[WW-1-bidx];
                    bidx++;
                end
                if (rise) begin
                    dsh = {dsh[6:0], din};
                    rbits++;
                    if (din) ones++;
                    if (rbits == 8 && dsh == 8'h58) begin
                        mc = 0; pres = 0; dr = 1'b1; exits++;
                    end else if (rbits == WW) begin
                        pres = 0; dr = 1'b1; reads++;
                        if (ones != 0) dirty++;
                    end
                end
            end else if (rise || fall) bad_edges++;
            timer--;
            if (timer <= 0) begin
                timer = $urandom_range(160, 260);
                if (mc && !csn) begin
                    if (pres) lost++;
                    cur = {8'h00, 24'($urandom)};
                    pres = 1; rbits = 0; bidx = 0; ones = 0; dr = 1'b0;
                end
            end
        end
    end

    task automatic pulse(ref logic s);
        @(negedge clk); s = 1'b1;
        @(negedge clk); s = 1'b0;
    endtask

    task automatic wait_words(input int n);
        int target;
        target = vcount + n;
        while (vcount < target) @(negedge clk);
    endtask

    task automatic run_all();
        int v0, e0;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(csn && sclk && !din && !vld && !ovr, "R1 reset lines",
            {csn, sclk, din, vld, ovr}, 5'b11000);
        pulse(stop);
        repeat (30) @(negedge clk);
        chk(csn == 1'b1, "R10 stop while idle", csn, 1);
        chk(enters == 0, "R10 no command while idle", enters, 0);
        pulse(start);
        while (!mc) @(negedge clk);
        chk(last_cmd == 8'h5C, "R2 enter byte", last_cmd, 8'h5C);
        chk(hp_min == DIV && hp_max == DIV, "R2 half period", hp_max, DIV);
        wait_words(6);
        chk(bad_edges == 0, "R3 R5 clocks outside a ready word", bad_edges, 0);
        chk(reads == vcount, "R4 full reads match strobes", reads, vcount);
        chk(dirty == 0, "R6 command line low while reading", dirty, 0);
        chk(floods == 0, "R6 no run of 40 ones", floods, 0);
        chk(lost == 0, "R4 no conversion overwritten", lost, 0);
        chk(ovr == 1'b0, "R9 no overrun with prompt ack", ovr, 0);
        pulse(start);
        wait_words(2);
        chk(enters == 1 && !csn, "R10 start during session", enters, 1);
        ack = 1'b0;
        wait_words(2);
        @(negedge clk);
        chk(ovr == 1'b1, "R9 overrun on unacked word", ovr, 1);
        ack = 1'b1;
        wait_words(1);
        chk(ovr == 1'b1, "R9 overrun sticky", ovr, 1);
        repeat (5) @(negedge clk);
        v0 = vcount; e0 = exits;
        pulse(stop);
        repeat (20) @(negedge clk);
        chk(!csn && mc, "R7 exit waits for ready", csn, 0);
        while (!csn) @(negedge clk);
        chk(exits == e0 + 1, "R7 exit byte seen", exits, e0 + 1);
        chk(vcount == v0, "R7 exit delivers no word", vcount, v0);
        chk(bad_edges == 0, "R7 exit clocked only while ready", bad_edges, 0);
        repeat (10) @(negedge clk);
        pulse(start);
        repeat (2) @(negedge clk);
        chk(ovr == 1'b0, "R9 cleared by start", ovr, 0);
        while (!mc) @(negedge clk);
        chk(enters == 2, "R2 second enter", enters, 2);
        wait_words(2);
        while (!(pres && rbits >= 4)) @(negedge clk);
        v0 = vcount; e0 = exits;
        pulse(stop);
        while (!csn) @(negedge clk);
        chk(vcount == v0 + 1, "R8 word in flight delivered", vcount, v0 + 1);
        chk(exits == e0 + 1, "R8 exit after word", exits, e0 + 1);
        chk(lost == 0 && floods == 0, "R6 no loss or flood", lost + floods, 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                nchk++; nfail++;
                $display("FAIL watchdog actual=expired expected=done");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule